// File: doc/BRIEF.md
# Auxiliary-Channel Request Framer

This block turns one auxiliary-channel request into the byte stream a transmitter sends, and places that stream in a small internal transmit buffer. A request has a 4-bit command, a 20-bit address, a payload length of up to `MAX_LEN` bytes, a start delay and, for writes, the payload bytes. The framer writes the bytes into the buffer one per cycle. The order is three header bytes that carry the command and the address, then a length byte when the length is non-zero, then the payload when the command is a write. When the last byte is in the buffer, the framer presents the total byte count and pulses a start strobe to the transmitter.

Before any byte is written, the framer pulses an acknowledge for the transmitter's completion flag. It then waits for that flag to read low, so a stale completion from an earlier request cannot be taken for the new one. A request whose length exceeds `MAX_LEN` is refused with a one-cycle error pulse. The buffer is read back through a combinational index port, which the downstream serializer uses.

Top module: `aux_req_framer`

## Requirements
- R1: After synchronous active-low reset, `busy`, `go`, `done_ack` and `err` are low and `wr_bytes` is 0.
- R2: Buffer byte 0 holds the command in bits 7:4 and address bits 19:16 in bits 3:0. Byte 1 holds address bits 15:8 and byte 2 holds address bits 7:0.
- R3: When the length is non-zero, byte 3 holds the length minus one. When the length is zero, no length byte is framed.
- R4: Commands 4'h8 (native write), 4'h0 (I2C write) and 4'h4 (I2C write, transaction continues) are writes, and every other command is a read. For a write, payload byte i (bits 8i+7:8i of `req_data`) is placed at buffer index 4+i. For a read, no payload is framed.
- R5: `wr_bytes` equals 3 for a zero length and 4 otherwise, plus the length for a write.
- R6: `done_ack` is high for exactly the one cycle after acceptance. No byte is loaded while `done_in` is high after that cycle.
- R7: With `done_in` low, `go` pulses for one cycle, exactly `wr_bytes`+3 cycles after the accepting edge. It is issued only after the last byte is written.
- R8: `busy` is high from the cycle after acceptance through the `go` cycle and low after it. `req_valid` while busy is ignored.
- R9: A request with a length above `MAX_LEN` is rejected. `err` is high for the following single cycle, `busy` stays low, and the buffer and `wr_bytes` keep their previous values.
- R10: `start_delay` presents the delay captured with the accepted request.
- R11: `rd_byte` shows the buffer entry at `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when idle |
| req_cmd | input | 4 | Request command |
| req_addr | input | 20 | Request address |
| req_len | input | LEN_W | Payload length in bytes |
| req_delay | input | DLY_W | Start delay for the transmitter |
| req_data | input | MAX_LEN*8 | Payload, byte i at bits 8i+7:8i |
| done_in | input | 1 | Transmitter completion flag |
| done_ack | output | 1 | Acknowledge pulse for the completion flag |
| busy | output | 1 | Framing in progress |
| err | output | 1 | Oversized request rejected |
| go | output | 1 | Start strobe, one cycle |
| wr_bytes | output | CNT_W | Bytes to send |
| start_delay | output | DLY_W | Captured start delay |
| rd_idx | input | IDX_W | Buffer read index |
| rd_byte | output | 8 | Buffer byte at rd_idx |

## Verification
The bench uses the default `MAX_LEN` of 16, which gives a 20-entry buffer and 5-bit counts. With those values the bench can sweep all sixteen command codes against every length from 0 to 16 and compare every framed byte, the byte count and the strobe cycle against arithmetic expectations. Separate runs cover the length-17 rejection, a completion flag held high for several cycles, and a request driven during the busy window.

// File: rtl/aux_req_framer_pkg.sv
// Package: shared state type and command classification for the framer.
// Assumes command codes follow the 4-bit auxiliary-channel request encoding.
package aux_req_framer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_WAIT,
        ST_LOAD,
        ST_FIRE
    } frm_state_t;

    localparam logic [3:0] CMD_NATIVE_WR  = 4'h8;
    localparam logic [3:0] CMD_I2C_WR     = 4'h0;
    localparam logic [3:0] CMD_I2C_WR_MOT = 4'h4;

    // Returns 1 when the command carries payload bytes.
    function automatic logic cmd_is_write(input logic [3:0] cmd);
        return (cmd == CMD_NATIVE_WR) || (cmd == CMD_I2C_WR) ||
               (cmd == CMD_I2C_WR_MOT);
    endfunction

endpackage

// File: rtl/aux_frm_seq.sv
// Sequencer: accepts or rejects a request, acknowledges the done flag,
// waits for it to clear, loads one byte per cycle, then fires go.
// Assumes total is stable from the cycle after acceptance onward.
module aux_frm_seq
    import aux_req_framer_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             len_ok,
    input  logic             done_in,
    input  logic [CNT_W-1:0] ptr,
    input  logic [CNT_W-1:0] total,
    output logic             accept,
    output logic             reject,
    output logic             ptr_clr,
    output logic             wr_en,
    output logic             done_ack,
    output logic             busy,
    output logic             go
);

    frm_state_t state, state_nx;
    logic       last_byte;

    assign last_byte = (ptr == total - CNT_W'(1));

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (accept)   state_nx = ST_ACK;
            ST_ACK:                state_nx = ST_WAIT;
            ST_WAIT: if (!done_in) state_nx = ST_LOAD;
            ST_LOAD: if (last_byte) state_nx = ST_FIRE;
            ST_FIRE:               state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign accept   = (state == ST_IDLE) && req_valid && len_ok;
    assign reject   = (state == ST_IDLE) && req_valid && !len_ok;
    assign ptr_clr  = (state == ST_ACK);
    assign done_ack = (state == ST_ACK);
    assign wr_en    = (state == ST_LOAD);
    assign go       = (state == ST_FIRE);
    assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/aux_frm_bytesel.sv
// Byte selector: returns the frame byte for a buffer index from the
// captured request. Assumes only indices below the byte count are used.
module aux_frm_bytesel #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5,
    parameter int IDX_W   = 5
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic [3:0]           cmd,
    input  logic [19:0]          addr,
    input  logic [LEN_W-1:0]     len,
    input  logic [MAX_LEN*8-1:0] data,
    output logic [7:0]           byte_out
);

    logic [IDX_W-1:0] off;
    logic [7:0]       pay;

    assign off = idx - IDX_W'(4);

    // Payload byte pick for indices from 4 upward.
    always_comb begin
        pay = 8'h00;
        for (int i = 0; i < MAX_LEN; i++) begin
            if (off == IDX_W'(i)) pay = data[8*i +: 8];
        end
    end

    // Header, length or payload byte by position.
    always_comb begin
        case (idx)
            IDX_W'(0): byte_out = {cmd, addr[19:16]};
            IDX_W'(1): byte_out = addr[15:8];
            IDX_W'(2): byte_out = addr[7:0];
            IDX_W'(3): byte_out = 8'(len) - 8'd1;
            default:   byte_out = pay;
        endcase
    end

endmodule

// File: rtl/aux_frm_txbuf.sv
// Transmit buffer: byte array with a write pointer that is cleared at frame
// start and advances after each write; combinational read port.
module aux_frm_txbuf #(
    parameter int DEPTH = 20,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_clr,
    input  logic             wr_en,
    input  logic [7:0]       wr_byte,
    output logic [IDX_W-1:0] ptr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);

    logic [7:0] mem [DEPTH];

    // Pointer: cleared per frame, advances on each write.
    always_ff @(posedge clk) begin
        if (!rst_n || ptr_clr) ptr <= '0;
        else if (wr_en)        ptr <= ptr + IDX_W'(1);
    end

    // Storage write at the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++)
                if (ptr == IDX_W'(i)) mem[i] <= wr_byte;
        end
    end

    // Read mux; indices past the depth read as zero.
    always_comb begin
        rd_byte = 8'h00;
        for (int i = 0; i < DEPTH; i++)
            if (rd_idx == IDX_W'(i)) rd_byte = mem[i];
    end

endmodule

// File: rtl/aux_req_framer.sv
// Top: captures a request, computes the byte count, and drives the
// sequencer, byte selector and transmit buffer. Requests are taken only
// when idle; lengths above MAX_LEN are refused.
module aux_req_framer
    import aux_req_framer_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int DLY_W   = 4,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int CNT_W   = $clog2(MAX_LEN + 5),
    parameter int IDX_W   = CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [3:0]           req_cmd,
    input  logic [19:0]          req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [DLY_W-1:0]     req_delay,
    input  logic [MAX_LEN*8-1:0] req_data,
    input  logic                 done_in,
    output logic                 done_ack,
    output logic                 busy,
    output logic                 err,
    output logic                 go,
    output logic [CNT_W-1:0]     wr_bytes,
    output logic [DLY_W-1:0]     start_delay,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [7:0]           rd_byte
);

    localparam int DEPTH = MAX_LEN + 4;

    logic                 accept, reject, ptr_clr, wr_en, len_ok;
    logic [IDX_W-1:0]     ptr;
    logic [7:0]           wr_byte;
    logic [3:0]           cmd_q;
    logic [19:0]          addr_q;
    logic [LEN_W-1:0]     len_q;
    logic [MAX_LEN*8-1:0] data_q;
    logic [CNT_W-1:0]     total_nx;

    assign len_ok = (int'(req_len) <= MAX_LEN);

    // Byte count for the incoming request.
    always_comb begin
        total_nx = (req_len != '0) ? CNT_W'(4) : CNT_W'(3);
        if (cmd_is_write(req_cmd)) total_nx = total_nx + CNT_W'(req_len);
    end

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q       <= '0;
            addr_q      <= '0;
            len_q       <= '0;
            data_q      <= '0;
            wr_bytes    <= '0;
            start_delay <= '0;
        end else if (accept) begin
            cmd_q       <= req_cmd;
            addr_q      <= req_addr;
            len_q       <= req_len;
            data_q      <= req_data;
            wr_bytes    <= total_nx;
            start_delay <= req_delay;
        end
    end

    // Rejection pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= reject;
    end

    aux_frm_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .len_ok   (len_ok),
        .done_in  (done_in),
        .ptr      (ptr),
        .total    (wr_bytes),
        .accept   (accept),
        .reject   (reject),
        .ptr_clr  (ptr_clr),
        .wr_en    (wr_en),
        .done_ack (done_ack),
        .busy     (busy),
        .go       (go)
    );

    aux_frm_bytesel #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_sel (
        .idx     (ptr),
        .cmd     (cmd_q),
        .addr    (addr_q),
        .len     (len_q),
        .data    (data_q),
        .byte_out(wr_byte)
    );

    aux_frm_txbuf #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ptr_clr(ptr_clr),
        .wr_en  (wr_en),
        .wr_byte(wr_byte),
        .ptr    (ptr),
        .rd_idx (rd_idx),
        .rd_byte(rd_byte)
    );

endmodule

// File: rtl/aux_req_framer_chk.sv
// Checker: temporal properties of the framer's handshake outputs.
module aux_req_framer_chk #(
    parameter int CNT_W   = 5,
    parameter int MAX_LEN = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic             busy,
    input logic             err,
    input logic             done_ack,
    input logic [CNT_W-1:0] wr_bytes
);

    AST_GO_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) go |=> !go);         // R7
    AST_BUSY_AT_GO: assert property (@(posedge clk) disable iff (!rst_n) go |-> busy);        // R8
    AST_BUSY_DROP:  assert property (@(posedge clk) disable iff (!rst_n) go |=> !busy);       // R8
    AST_ACK_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done_ack |=> !done_ack); // R6
    AST_ACK_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) done_ack |-> busy);  // R6
    AST_ERR_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) err |-> !busy);      // R9
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (int'(wr_bytes) >= 3 && int'(wr_bytes) <= MAX_LEN + 4));                       // R5

endmodule

bind aux_req_framer aux_req_framer_chk #(.CNT_W(CNT_W), .MAX_LEN(MAX_LEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .busy    (busy),
    .err     (err),
    .done_ack(done_ack),
    .wr_bytes(wr_bytes)
);

// File: tb/aux_req_framer_bench.sv
module aux_req_framer_bench;

    localparam int MAX_LEN = 16;
    localparam int DLY_W   = 4;
    localparam int LEN_W   = 5;
    localparam int CNT_W   = 5;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic [3:0]           req_cmd = '0;
    logic [19:0]          req_addr = '0;
    logic [LEN_W-1:0]     req_len = '0;
    logic [DLY_W-1:0]     req_delay = '0;
    logic [MAX_LEN*8-1:0] req_data = '0;
    logic                 done_in = 1'b0;
    logic                 done_ack, busy, err, go;
    logic [CNT_W-1:0]     wr_bytes;
    logic [DLY_W-1:0]     start_delay;
    logic [CNT_W-1:0]     rd_idx = '0;
    logic [7:0]           rd_byte;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    aux_req_framer u_aux_req_framer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .req_delay(req_delay),
        .req_data(req_data), .done_in(done_in), .done_ack(done_ack),
        .busy(busy), .err(err), .go(go), .wr_bytes(wr_bytes),
        .start_delay(start_delay), .rd_idx(rd_idx), .rd_byte(rd_byte)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_wr(input int c);
        return (c == 8) || (c == 0) || (c == 4);
    endfunction

    function automatic int pay_byte(input int c, input int l, input int i);
        return (c * 17 + l * 5 + i * 29 + 3) & 255;
    endfunction

    function automatic int mk_addr(input int c, input int l);
        return (c * 32'h12345 + l * 32'h9A7 + 32'h5) & 32'hFFFFF;
    endfunction

    function automatic int exp_count(input int c, input int l);
        return ((l != 0) ? 4 : 3) + (is_wr(c) ? l : 0);
    endfunction

    function automatic int exp_byte(input int c, input int a, input int l, input int i);
        if (i == 0) return (c << 4) | ((a >> 16) & 15);
        if (i == 1) return (a >> 8) & 255;
        if (i == 2) return a & 255;
        if (i == 3) return (l - 1) & 255;
        return pay_byte(c, l, i - 4);
    endfunction

    task automatic read_buf(input int i, output int b);
        rd_idx = CNT_W'(i);
        #1;
        b = int'(rd_byte);
    endtask

    // One framed request; hold = cycles done_in is forced high (0 = none);
    // disturb = drive a competing request while busy.
    task automatic run_req(input int c, input int l, input int hold, input bit disturb);
        int a, k, exp_k, n, b;
        a = mk_addr(c, l);
        n = exp_count(c, l);
        exp_k = n + 3 + ((hold > 1) ? hold - 1 : 0);
        @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = 4'(c);
        req_addr  = 20'(a);
        req_len   = LEN_W'(l);
        req_delay = DLY_W'(c + l);
        for (int i = 0; i < MAX_LEN; i++) req_data[8*i +: 8] = 8'(pay_byte(c, l, i));
        if (hold > 0) done_in = 1'b1;
        k = 0;
        while (k < 80) begin
            @(negedge clk);
            k++;
            if (k == 1) begin
                req_valid = 1'b0;
                chk("R6 ack pulse", int'(done_ack), 1);
                chk("R8 busy after accept", int'(busy), 1);
            end
            if (k == 2) chk("R6 ack single", int'(done_ack), 0);
            if (k == hold + 1) done_in = 1'b0;
            if (disturb && k == 2) begin
                req_valid = 1'b1;
                req_cmd   = ~4'(c);
                req_addr  = ~20'(a);
                req_len   = LEN_W'(3);
            end
            if (disturb && k == 3) req_valid = 1'b0;
            if (go) break;
        end
        chk("R7 go cycle", k, exp_k);
        chk("R8 busy at go", int'(busy), 1);
        chk("R5 byte count", int'(wr_bytes), n);
        chk("R10 start delay", int'(start_delay), (c + l) & 15);
        for (int i = 0; i < n; i++) begin
            read_buf(i, b);
            if (i < 3)       chk("R2 header byte", b, exp_byte(c, a, l, i));
            else if (i == 3) chk("R3 length byte", b, exp_byte(c, a, l, i));
            else             chk("R4 payload byte", b, exp_byte(c, a, l, i));
        end
        @(negedge clk);
        chk("R7 go single", int'(go), 0);
        chk("R8 busy released", int'(busy), 0);
        if (disturb) begin
            @(negedge clk);
            chk("R8 ignored request no new frame", int'(busy), 0);
        end
    endtask

    bit finished = 1'b0;

    initial begin
        int b0, wb;
        repeat (3) @(negedge clk);
        chk("R1 busy reset", int'(busy), 0);
        chk("R1 go reset", int'(go), 0);
        chk("R1 ack reset", int'(done_ack), 0);
        chk("R1 err reset", int'(err), 0);
        chk("R1 count reset", int'(wr_bytes), 0);
        rst_n = 1'b1;
        read_buf(0, b0);
        chk("R11 buffer reads zero after reset", b0, 0);

        for (int c = 0; c < 16; c++)
            for (int l = 0; l <= MAX_LEN; l++)
                run_req(c, l, 0, 1'b0);

        run_req(8, 5, 5, 1'b0);
        run_req(1, 0, 3, 1'b0);
        run_req(0, 2, 0, 1'b1);
        run_req(9, 4, 0, 1'b1);

        // R9: oversized length rejected, state untouched.
        read_buf(0, b0);
        wb = int'(wr_bytes);
        @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = 4'h8;
        req_addr  = 20'hABCDE;
        req_len   = LEN_W'(MAX_LEN + 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 err pulse", int'(err), 1);
        chk("R9 no busy", int'(busy), 0);
        @(negedge clk);
        chk("R9 err single", int'(err), 0);
        chk("R9 no busy later", int'(busy), 0);
        chk("R9 count kept", int'(wr_bytes), wb);
        read_buf(0, b);
        chk("R9 buffer kept", b, b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    int b;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

endmodule